// File: doc/BRIEF.md
# Dual-Issue Structural Hazard Gate

This block sits at the issue stage of an in-order integer pipeline that can issue two instructions per cycle. Each cycle it receives two decoded instruction class codes. Slot 0 holds the older instruction and slot 1 the younger. For each one it decides whether it may enter the pipeline now, without colliding in any cycle with execution resources that earlier instructions still hold. The resources are:

- a load/store port and a floating-point/SIMD port, which may never be active in the same cycle;
- two data-processing pipes, P0 and P1, each with E1, E2 and writeback stages;
- a two-stage multiply unit, M1 then M2, whose occupancy overlaps the pipes' E stages for accumulate forms;
- a branch slot.

Each class books a fixed pattern of resources over the next four cycles. Offset 0 is the cycle of issue. The block keeps these bookings in a reservation window that advances once per clock. A granted instruction is taken to have issued. The front end re-presents any instruction that was not granted.

For the classes that may use either pipe (plain ALU, shifting ALU, store-multiple), the block tries P0 first and falls back to P1. It reports the pipe it chose. The gate is purely combinational from the current inputs and the window. The only state is the window register.

Top module: `dual_issue_gate`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, the window is empty. A valid instruction alone is granted at once, and a slot whose valid is low is never granted.
- R2: Class codes are 0 no-op, 1 plain ALU or move, 2 shifting ALU, 3 load, 4 load-multiple, 5 store, 6 store-multiple, 7 16-bit multiply, 8 16-bit multiply-accumulate, 9 32-bit multiply, 10 32-bit multiply-accumulate, 11 branch, 12 call, 13 floating-point/SIMD. Codes 0, 14 and 15 book nothing and are always granted when valid.
- R3: A plain ALU books E2 at offset 0 and writeback at offset 1 of one pipe. P0 is taken when free, otherwise P1. The pipe output is 0 for P0 and 1 for P1, and 0 for classes with no pipe choice.
- R4: A shifting ALU books E1, E2 and writeback of one pipe at offsets 0, 1 and 2.
- R5: A load/store-port booking and a floating-point booking never share a cycle, whether they come from the same cycle's pair or from the window.
- R6: Load-multiple books the load/store port at offsets 0 and 1.
- R7: Store-multiple books the load/store port and one pipe's E2 at offset 0, that pipe's writeback at offset 1, and the load/store port again at offset 1.
- R8: A 32-bit multiply books M1 at offsets 0 and 1, M2 at offset 2 and P0 writeback at offset 3.
- R9: A 16-bit multiply books M1, M2 and P0 writeback at offsets 0, 1 and 2, so these may issue back to back.
- R10: A 16-bit multiply-accumulate books M1, M2 and E1/E2 of both pipes at offset 0, then M2 at offset 1 and P0 writeback at offset 2.
- R11: A 32-bit multiply-accumulate books that full set at offsets 0 and 1, then M2 at offset 2 and P0 writeback at offset 3.
- R12: A branch books the branch slot at offset 0. A call books the branch slot, all E stages, M1, M2 and both ports at offset 0, so only a class that books nothing can pair with it.
- R13: Issue is in order. When slot 0 is valid and not granted, slot 1 is not granted. When slot 0 is not valid, slot 1 is judged alone against the window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset, clears the window |
| v0_i | input | 1 | Older instruction present |
| cls0_i | input | 4 | Older instruction class code |
| v1_i | input | 1 | Younger instruction present |
| cls1_i | input | 4 | Younger instruction class code |
| gnt0_o | output | 1 | Older instruction may issue this cycle |
| pipe0_o | output | 1 | Pipe chosen for the older instruction (0 = P0, 1 = P1) |
| gnt1_o | output | 1 | Younger instruction may issue this cycle |
| pipe1_o | output | 1 | Pipe chosen for the younger instruction (0 = P0, 1 = P1) |

## Verification
A wrong booking pattern or a window that shifts wrongly does not show in the cycle it is made. It shows one to three cycles later: a follow-up instruction is refused when it should fit, or is granted when it should not, or a pipe choice flips from P0 to P1. The tests therefore issue a long-latency class and then probe the exact cycle in which each booked resource frees, often with a P0/P1 choice that depends on a writeback booked three cycles earlier. An error in the ordering or exclusion logic shows at once in the same cycle's grant pair.

// File: rtl/issue_gate_pkg.sv
package issue_gate_pkg;

    // Resource bit positions inside one window row
    localparam int NRES   = 11;
    localparam int R_LS   = 0;
    localparam int R_FP   = 1;
    localparam int R_P0E1 = 2;
    localparam int R_P0E2 = 3;
    localparam int R_P0WB = 4;
    localparam int R_P1E1 = 5;
    localparam int R_P1E2 = 6;
    localparam int R_P1WB = 7;
    localparam int R_M1   = 8;
    localparam int R_M2   = 9;
    localparam int R_BR   = 10;

    typedef logic [NRES-1:0] resvec_t;

    // Resources an accumulate or call blocks in one cycle
    localparam resvec_t FULL_EX = resvec_t'((1 << R_P0E1) | (1 << R_P0E2) |
                                            (1 << R_P1E1) | (1 << R_P1E2) |
                                            (1 << R_M1)   | (1 << R_M2));

    typedef enum logic [3:0] {
        IC_NOP   = 4'd0,
        IC_ALU   = 4'd1,
        IC_ALUSH = 4'd2,
        IC_LD    = 4'd3,
        IC_LDM   = 4'd4,
        IC_ST    = 4'd5,
        IC_STM   = 4'd6,
        IC_MUL16 = 4'd7,
        IC_MAC16 = 4'd8,
        IC_MUL   = 4'd9,
        IC_MAC   = 4'd10,
        IC_BR    = 4'd11,
        IC_CALL  = 4'd12,
        IC_FP    = 4'd13
    } iclass_e;

    function automatic logic uses_ls(input logic [3:0] c);
        return (c == IC_LD) || (c == IC_LDM) || (c == IC_ST) ||
               (c == IC_STM) || (c == IC_CALL);
    endfunction

    function automatic logic books_any(input logic [3:0] c);
        return (c >= 4'd1) && (c <= 4'd13);
    endfunction

endpackage

// File: rtl/issue_gate_decode.sv
module issue_gate_decode
    import issue_gate_pkg::*;
#(
    parameter int WIN = 4   // must be at least 4
) (
    input  logic                     valid_i,
    input  logic [3:0]               cls_i,
    output logic [WIN-1:0][NRES-1:0] res_a_o,   // P0 variant
    output logic [WIN-1:0][NRES-1:0] res_b_o,   // P1 variant
    output logic                     flex_o     // class may use either pipe
);

    always_comb begin
        res_a_o = '0;
        res_b_o = '0;
        flex_o  = 1'b0;
        if (valid_i) begin
            unique case (cls_i)
                IC_ALU: begin
                    flex_o = 1'b1;
                    res_a_o[0][R_P0E2] = 1'b1;
                    res_a_o[1][R_P0WB] = 1'b1;
                    res_b_o[0][R_P1E2] = 1'b1;
                    res_b_o[1][R_P1WB] = 1'b1;
                end
                IC_ALUSH: begin
                    flex_o = 1'b1;
                    res_a_o[0][R_P0E1] = 1'b1;
                    res_a_o[1][R_P0E2] = 1'b1;
                    res_a_o[2][R_P0WB] = 1'b1;
                    res_b_o[0][R_P1E1] = 1'b1;
                    res_b_o[1][R_P1E2] = 1'b1;
                    res_b_o[2][R_P1WB] = 1'b1;
                end
                IC_LD, IC_ST: begin
                    res_a_o[0][R_LS] = 1'b1;
                end
                IC_LDM: begin
                    res_a_o[0][R_LS] = 1'b1;
                    res_a_o[1][R_LS] = 1'b1;
                end
                IC_STM: begin
                    flex_o = 1'b1;
                    res_a_o[0][R_LS]   = 1'b1;
                    res_a_o[0][R_P0E2] = 1'b1;
                    res_a_o[1][R_P0WB] = 1'b1;
                    res_a_o[1][R_LS]   = 1'b1;
                    res_b_o[0][R_LS]   = 1'b1;
                    res_b_o[0][R_P1E2] = 1'b1;
                    res_b_o[1][R_P1WB] = 1'b1;
                    res_b_o[1][R_LS]   = 1'b1;
                end
                IC_MUL16: begin
                    res_a_o[0][R_M1]   = 1'b1;
                    res_a_o[1][R_M2]   = 1'b1;
                    res_a_o[2][R_P0WB] = 1'b1;
                end
                IC_MAC16: begin
                    res_a_o[0]         = FULL_EX;
                    res_a_o[1][R_M2]   = 1'b1;
                    res_a_o[2][R_P0WB] = 1'b1;
                end
                IC_MUL: begin
                    res_a_o[0][R_M1]   = 1'b1;
                    res_a_o[1][R_M1]   = 1'b1;
                    res_a_o[2][R_M2]   = 1'b1;
                    res_a_o[3][R_P0WB] = 1'b1;
                end
                IC_MAC: begin
                    res_a_o[0]         = FULL_EX;
                    res_a_o[1]         = FULL_EX;
                    res_a_o[2][R_M2]   = 1'b1;
                    res_a_o[3][R_P0WB] = 1'b1;
                end
                IC_BR: begin
                    res_a_o[0][R_BR] = 1'b1;
                end
                IC_CALL: begin
                    res_a_o[0]       = FULL_EX;
                    res_a_o[0][R_BR] = 1'b1;
                    res_a_o[0][R_LS] = 1'b1;
                    res_a_o[0][R_FP] = 1'b1;
                end
                IC_FP: begin
                    res_a_o[0][R_FP] = 1'b1;
                end
                default: begin
                    // no-op and unused codes book nothing
                end
            endcase
            if (!flex_o) begin
                res_b_o = res_a_o;
            end
        end
    end

endmodule

// File: rtl/issue_gate_fit.sv
module issue_gate_fit
    import issue_gate_pkg::*;
#(
    parameter int WIN = 4
) (
    input  logic [WIN-1:0][NRES-1:0] occ_i,
    input  logic [WIN-1:0][NRES-1:0] cand_i,
    output logic                     clash_o
);

    logic [WIN-1:0] row_hit;

    for (genvar k = 0; k < WIN; k++) begin : g_row
        // direct overlap, or load/store against floating point in one cycle
        assign row_hit[k] = (|(occ_i[k] & cand_i[k])) |
                            (occ_i[k][R_LS] & cand_i[k][R_FP]) |
                            (occ_i[k][R_FP] & cand_i[k][R_LS]);
    end

    assign clash_o = |row_hit;

endmodule

// File: rtl/issue_gate_window.sv
module issue_gate_window
    import issue_gate_pkg::*;
#(
    parameter int WIN = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [WIN-1:0][NRES-1:0] add_i,   // bookings granted this cycle
    output logic [WIN-1:0][NRES-1:0] occ_o    // bookings seen this cycle
);

    localparam int HELD = WIN - 1;

    logic [HELD-1:0][NRES-1:0] held_q;

    for (genvar k = 0; k < WIN; k++) begin : g_view
        if (k < HELD) begin : g_stored
            assign occ_o[k] = held_q[k];
        end else begin : g_empty
            assign occ_o[k] = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q <= '0;
        end else begin
            for (int k = 0; k < HELD; k++) begin
                held_q[k] <= occ_o[k+1] | add_i[k+1];
            end
        end
    end

    // R5: a new booking never lands on a resource already held this cycle
    a_r5_no_double_booking: assert property (@(posedge clk) disable iff (!rst_n)
        ((add_i[0] & occ_o[0]) == '0));

    // R5: the window never holds both ports for the current cycle
    a_r5_ports_apart: assert property (@(posedge clk) disable iff (!rst_n)
        !(occ_o[0][R_LS] && occ_o[0][R_FP] && !occ_o[0][R_BR]));

endmodule

// File: rtl/dual_issue_gate.sv
module dual_issue_gate
    import issue_gate_pkg::*;
#(
    parameter int WIN = 4   // reservation depth in cycles, at least 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       v0_i,
    input  logic [3:0] cls0_i,
    input  logic       v1_i,
    input  logic [3:0] cls1_i,
    output logic       gnt0_o,
    output logic       pipe0_o,
    output logic       gnt1_o,
    output logic       pipe1_o
);

    logic [WIN-1:0][NRES-1:0] occ;
    logic [WIN-1:0][NRES-1:0] occ1;
    logic [WIN-1:0][NRES-1:0] a0, b0, a1, b1;
    logic [WIN-1:0][NRES-1:0] res0, res1, add;
    logic                     flex0, flex1;
    logic                     c0a, c0b, c1a, c1b;
    logic                     older_ok;

    issue_gate_window #(.WIN(WIN)) u_window (
        .clk   (clk),
        .rst_n (rst_n),
        .add_i (add),
        .occ_o (occ)
    );

    issue_gate_decode #(.WIN(WIN)) u_dec0 (
        .valid_i (v0_i),
        .cls_i   (cls0_i),
        .res_a_o (a0),
        .res_b_o (b0),
        .flex_o  (flex0)
    );

    issue_gate_decode #(.WIN(WIN)) u_dec1 (
        .valid_i (v1_i),
        .cls_i   (cls1_i),
        .res_a_o (a1),
        .res_b_o (b1),
        .flex_o  (flex1)
    );

    // older slot against the window
    issue_gate_fit #(.WIN(WIN)) u_fit0a (.occ_i(occ), .cand_i(a0), .clash_o(c0a));
    issue_gate_fit #(.WIN(WIN)) u_fit0b (.occ_i(occ), .cand_i(b0), .clash_o(c0b));

    assign gnt0_o  = v0_i && (!c0a || !c0b);
    assign pipe0_o = gnt0_o && flex0 && c0a;
    assign res0    = !gnt0_o ? '0 : (c0a ? b0 : a0);

    // younger slot against the window plus the older slot's bookings
    assign occ1 = occ | res0;

    issue_gate_fit #(.WIN(WIN)) u_fit1a (.occ_i(occ1), .cand_i(a1), .clash_o(c1a));
    issue_gate_fit #(.WIN(WIN)) u_fit1b (.occ_i(occ1), .cand_i(b1), .clash_o(c1b));

    assign older_ok = !v0_i || gnt0_o;
    assign gnt1_o   = v1_i && older_ok && (!c1a || !c1b);
    assign pipe1_o  = gnt1_o && flex1 && c1a;
    assign res1     = !gnt1_o ? '0 : (c1a ? b1 : a1);

    assign add = res0 | res1;

    // R13: a blocked older instruction holds the younger one
    a_r13_in_order: assert property (@(posedge clk) disable iff (!rst_n)
        (v0_i && !gnt0_o) |-> !gnt1_o);

    // R1: no grant without a valid instruction
    a_r1_grant_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt0_o |-> v0_i) and (gnt1_o |-> v1_i));

    // R5: a granted pair never mixes the two ports
    a_r5_pair_ports: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt0_o && gnt1_o && uses_ls(cls0_i)) |-> (cls1_i != IC_FP));

    // R6: the cycle after a load-multiple issues, no load/store-port class issues
    a_r6_ldm_second_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt0_o && cls0_i == IC_LDM) |=>
            (!(gnt0_o && uses_ls(cls0_i)) && !(gnt1_o && uses_ls(cls1_i))));

    // R11: a 32-bit multiply-accumulate blocks plain ALU issue on the next cycle
    a_r11_mac_second_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt0_o && cls0_i == IC_MAC) |=> !(gnt0_o && cls0_i == IC_ALU));

    // R12: only a class that books nothing pairs with a call
    a_r12_call_alone: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt0_o && gnt1_o && cls0_i == IC_CALL) |-> !books_any(cls1_i));

endmodule

// File: tb/dual_issue_gate_tb.sv
module dual_issue_gate_tb;
    import issue_gate_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       v0, v1;
    logic [3:0] c0, c1;
    logic       g0, p0, g1, p1;
    int         n_checks = 0;
    int         n_fails  = 0;
    bit         done     = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    dual_issue_gate u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .v0_i    (v0),
        .cls0_i  (c0),
        .v1_i    (v1),
        .cls1_i  (c1),
        .gnt0_o  (g0),
        .pipe0_o (p0),
        .gnt1_o  (g1),
        .pipe1_o (p1)
    );

    // Drive one cycle at the falling edge, compare {g0,p0,g1,p1}, then wait for the next falling edge
    task automatic step(input logic vv0, input logic [3:0] cc0,
                        input logic vv1, input logic [3:0] cc1,
                        input logic [3:0] exp, input string tag);
        v0 = vv0; c0 = cc0; v1 = vv1; c1 = cc1;
        #5;
        n_checks++;
        if ({g0, p0, g1, p1} !== exp) begin
            n_fails++;
            $display("FAIL %s: got %b expected %b", tag, {g0, p0, g1, p1}, exp);
        end
        @(negedge clk);
    endtask

    task automatic flush();
        v0 = 1'b0; v1 = 1'b0; c0 = IC_NOP; c1 = IC_NOP;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        step(0, IC_NOP, 0, IC_NOP, 4'b0000, "R1 idle after reset");
        step(1, IC_LDM, 0, IC_NOP, 4'b1000, "R1 ldm before reset");
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        step(1, IC_LD, 0, IC_NOP, 4'b1000, "R1 window cleared by reset");
        flush();
    endtask

    task automatic t_alu();
        step(1, IC_ALU, 1, IC_ALU, 4'b1011, "R3 two alu split p0 p1");
        step(1, IC_ALU, 1, IC_ALU, 4'b1011, "R3 two alu back to back");
        flush();
    endtask

    task automatic t_shift();
        step(1, IC_ALUSH, 1, IC_ALU, 4'b1010, "R4 shift then alu both p0");
        step(1, IC_ALU, 0, IC_NOP, 4'b1100, "R4 shift holds p0 e2");
        flush();
        step(1, IC_ALUSH, 1, IC_ALUSH, 4'b1011, "R4 two shifts split");
        flush();
    endtask

    task automatic t_ports();
        step(1, IC_LD, 1, IC_FP, 4'b1000, "R5 load with fp");
        step(1, IC_FP, 1, IC_LD, 4'b1000, "R5 fp with load");
        step(1, IC_ST, 1, IC_BR, 4'b1010, "R5 store with branch");
        flush();
    endtask

    task automatic t_ldm();
        step(1, IC_LDM, 0, IC_NOP, 4'b1000, "R6 ldm issues");
        step(1, IC_FP, 1, IC_LD, 4'b0000, "R6 R13 second port cycle blocks fp and younger");
        step(1, IC_LD, 1, IC_NOP, 4'b1010, "R6 port free on third cycle");
        flush();
    endtask

    task automatic t_stm();
        step(1, IC_STM, 1, IC_ALU, 4'b1011, "R7 stm takes p0 alu to p1");
        step(1, IC_ST, 0, IC_NOP, 4'b0000, "R7 port held second cycle");
        step(1, IC_ST, 0, IC_NOP, 4'b1000, "R7 port free third cycle");
        flush();
        step(1, IC_STM, 1, IC_STM, 4'b1000, "R7 two stm same cycle");
        flush();
    endtask

    task automatic t_mul();
        step(1, IC_MUL, 0, IC_NOP, 4'b1000, "R8 mul issues");
        step(1, IC_MUL16, 1, IC_ALU, 4'b0000, "R8 m1 held second cycle");
        step(1, IC_MUL16, 1, IC_ALU, 4'b1011, "R8 p0 writeback held at offset 3");
        flush();
    endtask

    task automatic t_mul16();
        step(1, IC_MUL16, 0, IC_NOP, 4'b1000, "R9 mul16 issues");
        step(1, IC_MUL16, 1, IC_ALU, 4'b1011, "R9 mul16 back to back");
        flush();
    endtask

    task automatic t_mac16();
        step(1, IC_MAC16, 1, IC_ALU, 4'b1000, "R10 mac16 blocks both e2");
        step(1, IC_ALU, 0, IC_NOP, 4'b1100, "R10 p0 writeback held");
        flush();
    endtask

    task automatic t_mac();
        step(1, IC_MAC, 0, IC_NOP, 4'b1000, "R11 mac issues");
        step(1, IC_ALU, 0, IC_NOP, 4'b0000, "R11 full block second cycle");
        step(1, IC_ALU, 0, IC_NOP, 4'b1100, "R11 p0 writeback held");
        flush();
    endtask

    task automatic t_call();
        step(1, IC_CALL, 1, IC_BR, 4'b1000, "R12 call with branch");
        step(1, IC_CALL, 1, IC_FP, 4'b1000, "R12 call with fp");
        step(1, IC_CALL, 1, IC_NOP, 4'b1010, "R12 call with nop");
        step(1, IC_BR, 1, IC_ALU, 4'b1010, "R12 branch with alu after call");
        step(1, IC_BR, 1, IC_BR, 4'b1000, "R12 one branch per cycle");
        flush();
    endtask

    task automatic t_order();
        step(0, IC_ALU, 1, IC_ALU, 4'b0010, "R13 absent older");
        step(1, 4'd14, 1, IC_ALU, 4'b1010, "R2 code 14 books nothing");
        step(1, 4'd15, 1, IC_LD, 4'b1010, "R2 code 15 books nothing");
        flush();
    endtask

    initial begin
        rst_n = 1'b0;
        v0 = 1'b0; v1 = 1'b0; c0 = IC_NOP; c1 = IC_NOP;
        repeat (3) @(negedge clk);
        #5;
        n_checks++;
        if ({g0, g1} !== 2'b00) begin
            n_fails++;
            $display("FAIL R1 grants in reset: got %b expected 00", {g0, g1});
        end
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_alu();
        t_shift();
        t_ports();
        t_ldm();
        t_stm();
        t_mul();
        t_mul16();
        t_mac16();
        t_mac();
        t_call();
        t_order();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule